// File: doc/BRIEF.md
# Status Register and Write-Protection Guard

This block keeps the eight-bit status word of a serial memory device and decides whether each array write or status write may start. The serial command engine gives it a one-cycle strobe for every finished command: write-enable set, write-enable clear, status write (with its data byte) and array write (with the page number of the target address). It also sees the write-protect pin, which is active low, and the busy flag of the external self-timed write timer. For each status or array write it answers with a one-cycle accept or reject pulse. On an accept the external timer starts a cycle. When the timer's busy flag falls, the block closes that cycle.

Three bits are non-volatile: the status-lock bit and the two zone bits that choose the read-only part of the array. They are modelled as plain registers. A functional reset leaves them alone, and a separate factory-load input returns them to a default value. The block also reports the protection mode. Software protection comes from the zone bits. Hardware protection comes from the lock bit together with a low write-protect pin, whichever of the two was applied first.

Top module: `stsreg_guard`

## Requirements
- R1: `status_byte` carries the lock bit at b7, zeros at b6..b4, zone bit 1 at b3, zone bit 0 at b2, the write-enable latch (WEL) at b1 and write-in-progress (WIP) at b0.
- R2: The zone code {b3,b2} selects the read-only pages. With a 15-bit byte address and 64-byte pages, the page is address bits 14..6. Code 00 protects no page. Code 01 protects pages 180h..1FFh (bytes 6000h..7FFFh). Code 10 protects pages 100h..1FFh (bytes 4000h..7FFFh). Code 11 protects every page.
- R3: WEL is set by `wren_stb`. It is cleared by `wrdi_stb`, by `rst`, and when an accepted write completes. A write completes in the cycle after the one in which `cycle_busy` falls.
- R4: An array write or status write is rejected when WEL is 0. An array write whose page lies in the protected zone is also rejected.
- R5: When the lock bit is 1 and the sampled pin is low, a status write is rejected even with WEL set, and `prot_mode` reads 2. Only raising the pin leaves this state.
- R6: With WEL set, no write in progress, and either the lock bit at 0 or the pin high, a status write is accepted.
- R7: A status write changes only b7, b3 and b2, taking data bits 7, 3 and 2. The old values stay visible until the cycle completes. The three bits never change while WIP is 0, except through `factory_init`.
- R8: `rst` clears WEL and WIP and keeps the non-volatile bits. `factory_init` loads them with the default value, which is 0.
- R9: A rejected request leaves WEL unchanged and leaves WIP at 0.
- R10: Any write request made while WIP or `cycle_busy` is 1 is rejected.
- R11: Accept and reject pulses appear for one cycle, in the cycle after the strobe. At most one of the four pulses is high. An accept sets WIP in that same cycle. The pin is sampled through one register.
- R12: `prot_mode` is 0 when the zone code is 00 and hardware protection is off. It is 1 when the zone code is non-zero and hardware protection is off. It is 2 when hardware protection is on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high functional reset |
| factory_init | input | 1 | Loads the non-volatile bits with their default |
| wp_n | input | 1 | Write-protect pin, active low |
| wren_stb | input | 1 | Write-enable command complete |
| wrdi_stb | input | 1 | Write-disable command complete |
| wrsr_stb | input | 1 | Status-write command complete |
| wrsr_data | input | 8 | Data byte of the status write |
| write_stb | input | 1 | Array-write command complete |
| write_page | input | 9 | Page number latched at the start of the array write |
| cycle_busy | input | 1 | Busy flag of the external write timer |
| status_byte | output | 8 | Status word for the read-status command |
| write_ok | output | 1 | Array write accepted |
| write_rej | output | 1 | Array write rejected |
| wrsr_ok | output | 1 | Status write accepted |
| wrsr_rej | output | 1 | Status write rejected |
| prot_mode | output | 2 | 0 open, 1 software, 2 hardware protection |

## Verification
Accept and reject pulses are due one cycle after the strobe edge. WIP is set in that same cycle. WEL clears, and new status bits appear, one cycle after `cycle_busy` falls. A pin change shows in `prot_mode` after one register. The bench model advances on the same rising edge as the design, and all outputs are compared a quarter period later. The directed checks sample at that same point, right after the edge that captured each strobe.

// File: rtl/stsreg_pkg.sv
package stsreg_pkg;
  typedef enum logic [1:0] {
    MODE_OPEN = 2'd0,
    MODE_SOFT = 2'd1,
    MODE_HARD = 2'd2
  } prot_mode_e;

  typedef struct packed {
    logic       lock;
    logic [1:0] zone;
  } nv_bits_t;

  localparam int LOCK_POS  = 7;
  localparam int ZONE1_POS = 3;
  localparam int ZONE0_POS = 2;
endpackage

// File: rtl/stsreg_zone_dec.sv
module stsreg_zone_dec #(
  parameter int PG_W = 9
) (
  input  logic [1:0]      zone,
  input  logic [PG_W-1:0] page,
  output logic            hit
);
  localparam int TOP = PG_W - 1;

  always_comb begin
    unique case (zone)
      2'b00:   hit = 1'b0;
      2'b01:   hit = page[TOP] & page[TOP-1];
      2'b10:   hit = page[TOP];
      default: hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/stsreg_nv.sv
module stsreg_nv
  import stsreg_pkg::*;
#(
  parameter logic [2:0] NV_DEFAULT = 3'b000
) (
  input  logic     clk,
  input  logic     factory_init,
  input  logic     stage_en,
  input  nv_bits_t stage_val,
  input  logic     commit,
  output nv_bits_t nv_q
);
  nv_bits_t stage_q;

  always_ff @(posedge clk) begin
    if (stage_en) stage_q <= stage_val;
  end

  always_ff @(posedge clk) begin
    if (factory_init) nv_q <= nv_bits_t'(NV_DEFAULT);
    else if (commit)  nv_q <= stage_q;
  end
endmodule

// File: rtl/stsreg_gate.sv
module stsreg_gate (
  input  logic clk,
  input  logic rst,
  input  logic wren_stb,
  input  logic wrdi_stb,
  input  logic wrsr_stb,
  input  logic write_stb,
  input  logic cycle_busy,
  input  logic zone_hit,
  input  logic hw_lock,
  output logic wel_q,
  output logic wip_q,
  output logic sr_accept,
  output logic commit,
  output logic write_ok,
  output logic write_rej,
  output logic wrsr_ok,
  output logic wrsr_rej
);
  logic busy_q, kind_sr_q, busy_any, done, wr_accept;

  assign busy_any  = wip_q | cycle_busy;
  assign done      = wip_q & busy_q & ~cycle_busy;
  assign wr_accept = write_stb & wel_q & ~busy_any & ~zone_hit;
  assign sr_accept = wrsr_stb & ~write_stb & wel_q & ~busy_any & ~hw_lock;
  assign commit    = done & kind_sr_q & ~rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q    <= 1'b0;
      wip_q     <= 1'b0;
      kind_sr_q <= 1'b0;
      wel_q     <= 1'b0;
      write_ok  <= 1'b0;
      write_rej <= 1'b0;
      wrsr_ok   <= 1'b0;
      wrsr_rej  <= 1'b0;
    end else begin
      busy_q    <= cycle_busy;
      write_ok  <= wr_accept;
      write_rej <= write_stb & ~wr_accept;
      wrsr_ok   <= sr_accept;
      wrsr_rej  <= wrsr_stb & ~write_stb & ~sr_accept;
      if (done) begin
        wip_q <= 1'b0;
      end else if (wr_accept || sr_accept) begin
        wip_q     <= 1'b1;
        kind_sr_q <= sr_accept;
      end
      if (done || wrdi_stb) wel_q <= 1'b0;
      else if (wren_stb)    wel_q <= 1'b1;
    end
  end
endmodule

// File: rtl/stsreg_guard.sv
module stsreg_guard
  import stsreg_pkg::*;
#(
  parameter int         ADDR_W     = 15,
  parameter int         PAGE_W     = 6,
  parameter logic [2:0] NV_DEFAULT = 3'b000,
  localparam int        PG_W       = ADDR_W - PAGE_W
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            factory_init,
  input  logic            wp_n,
  input  logic            wren_stb,
  input  logic            wrdi_stb,
  input  logic            wrsr_stb,
  input  logic [7:0]      wrsr_data,
  input  logic            write_stb,
  input  logic [PG_W-1:0] write_page,
  input  logic            cycle_busy,
  output logic [7:0]      status_byte,
  output logic            write_ok,
  output logic            write_rej,
  output logic            wrsr_ok,
  output logic            wrsr_rej,
  output logic [1:0]      prot_mode
);
  logic       wp_q, zone_hit, hw_lock, wel, wip, sr_accept, commit;
  nv_bits_t   nv_q, stage_val;
  prot_mode_e mode;

  always_ff @(posedge clk) begin
    if (rst) wp_q <= 1'b1;
    else     wp_q <= wp_n;
  end

  assign hw_lock   = nv_q.lock & ~wp_q;
  assign stage_val = '{lock: wrsr_data[LOCK_POS],
                       zone: {wrsr_data[ZONE1_POS], wrsr_data[ZONE0_POS]}};

  stsreg_zone_dec #(.PG_W(PG_W)) u_zone (
    .zone (nv_q.zone),
    .page (write_page),
    .hit  (zone_hit)
  );

  stsreg_nv #(.NV_DEFAULT(NV_DEFAULT)) u_nv (
    .clk          (clk),
    .factory_init (factory_init),
    .stage_en     (sr_accept),
    .stage_val    (stage_val),
    .commit       (commit),
    .nv_q         (nv_q)
  );

  stsreg_gate u_gate (
    .clk        (clk),
    .rst        (rst),
    .wren_stb   (wren_stb),
    .wrdi_stb   (wrdi_stb),
    .wrsr_stb   (wrsr_stb),
    .write_stb  (write_stb),
    .cycle_busy (cycle_busy),
    .zone_hit   (zone_hit),
    .hw_lock    (hw_lock),
    .wel_q      (wel),
    .wip_q      (wip),
    .sr_accept  (sr_accept),
    .commit     (commit),
    .write_ok   (write_ok),
    .write_rej  (write_rej),
    .wrsr_ok    (wrsr_ok),
    .wrsr_rej   (wrsr_rej)
  );

  always_comb begin
    if (hw_lock)              mode = MODE_HARD;
    else if (nv_q.zone != '0) mode = MODE_SOFT;
    else                      mode = MODE_OPEN;
  end

  assign prot_mode   = mode;
  assign status_byte = {nv_q.lock, 3'b000, nv_q.zone, wel, wip};
endmodule

// File: rtl/stsreg_guard_chk.sv
module stsreg_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic       factory_init,
  input logic       wren_stb,
  input logic       wrdi_stb,
  input logic       wrsr_stb,
  input logic       write_stb,
  input logic       cycle_busy,
  input logic [7:0] status_byte,
  input logic       write_ok,
  input logic       write_rej,
  input logic       wrsr_ok,
  input logic       wrsr_rej,
  input logic [1:0] prot_mode
);
  p_no_wel_write_r4: assert property (@(posedge clk) disable iff (rst)
    (write_stb && !status_byte[1]) |=> write_rej);

  p_hw_lock_r5: assert property (@(posedge clk) disable iff (rst)
    (wrsr_stb && !write_stb && prot_mode == 2'd2) |=> wrsr_rej);

  p_nv_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (!factory_init && !status_byte[0]) |=> $stable({status_byte[7], status_byte[3:2]}));

  p_rej_keeps_wel_r9: assert property (@(posedge clk) disable iff (rst)
    ((write_rej || wrsr_rej) && !$past(wren_stb) && !$past(wrdi_stb))
      |-> (status_byte[1] == $past(status_byte[1])));

  p_busy_reject_r10: assert property (@(posedge clk) disable iff (rst)
    (write_stb && (cycle_busy || status_byte[0])) |=> write_rej);

  p_accept_wip_r11: assert property (@(posedge clk) disable iff (rst)
    (write_ok || wrsr_ok) |-> status_byte[0]);

  p_one_result_r11: assert property (@(posedge clk) disable iff (rst)
    $onehot0({write_ok, write_rej, wrsr_ok, wrsr_rej}));
endmodule

bind stsreg_guard stsreg_guard_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .factory_init (factory_init),
  .wren_stb     (wren_stb),
  .wrdi_stb     (wrdi_stb),
  .wrsr_stb     (wrsr_stb),
  .write_stb    (write_stb),
  .cycle_busy   (cycle_busy),
  .status_byte  (status_byte),
  .write_ok     (write_ok),
  .write_rej    (write_rej),
  .wrsr_ok      (wrsr_ok),
  .wrsr_rej     (wrsr_rej),
  .prot_mode    (prot_mode)
);

// File: tb/stsreg_guard_test.sv
module stsreg_guard_test;
  localparam int CLK_T  = 10;
  localparam int NPAGES = 512;

  logic       clk = 0, rst = 1, factory_init = 1, wp_n = 1;
  logic       wren_stb = 0, wrdi_stb = 0, wrsr_stb = 0, write_stb = 0, cycle_busy = 0;
  logic [7:0] wrsr_data = 0;
  logic [8:0] write_page = 0;
  logic [7:0] status_byte;
  logic       write_ok, write_rej, wrsr_ok, wrsr_rej;
  logic [1:0] prot_mode;

  int vectors = 0, miscompares = 0;
  bit cmp_on = 0;

  stsreg_guard uut (
    .clk(clk), .rst(rst), .factory_init(factory_init), .wp_n(wp_n),
    .wren_stb(wren_stb), .wrdi_stb(wrdi_stb), .wrsr_stb(wrsr_stb),
    .wrsr_data(wrsr_data), .write_stb(write_stb), .write_page(write_page),
    .cycle_busy(cycle_busy), .status_byte(status_byte), .write_ok(write_ok),
    .write_rej(write_rej), .wrsr_ok(wrsr_ok), .wrsr_rej(wrsr_rej),
    .prot_mode(prot_mode)
  );

  always #(CLK_T/2) clk = ~clk;

  // behavioural reference model
  logic [2:0] m_nv = 0, m_stage = 0;
  logic m_wel = 0, m_pend = 0, m_kind = 0, m_busyq = 0, m_wpq = 1;
  logic m_wok = 0, m_wrej = 0, m_sok = 0, m_srej = 0;

  function automatic bit in_zone(logic [1:0] z, int pg);
    case (z)
      2'b01:   return pg >= (3 * NPAGES) / 4;
      2'b10:   return pg >= NPAGES / 2;
      2'b11:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    bit done, anybusy, wacc, sacc, hw;
    done    = m_pend && m_busyq && !cycle_busy;
    anybusy = m_pend || cycle_busy;
    hw      = m_nv[2] && !m_wpq;
    wacc    = write_stb && m_wel && !anybusy && !in_zone(m_nv[1:0], int'(write_page));
    sacc    = wrsr_stb && !write_stb && m_wel && !anybusy && !hw;
    if (factory_init) m_nv = 3'b000;
    else if (!rst && done && m_kind) m_nv = m_stage;
    if (!rst && sacc) m_stage = {wrsr_data[7], wrsr_data[3], wrsr_data[2]};
    if (rst) begin
      m_wel = 0; m_pend = 0; m_kind = 0; m_busyq = 0;
      m_wok = 0; m_wrej = 0; m_sok = 0; m_srej = 0; m_wpq = 1;
    end else begin
      m_wok  = wacc;
      m_wrej = write_stb && !wacc;
      m_sok  = sacc;
      m_srej = wrsr_stb && !write_stb && !sacc;
      if (done) m_pend = 0;
      else if (wacc || sacc) begin m_pend = 1; m_kind = sacc; end
      if (done || wrdi_stb) m_wel = 0;
      else if (wren_stb) m_wel = 1;
      m_busyq = cycle_busy;
      m_wpq   = wp_n;
    end
    cmp_on = 1;
  end

  function automatic logic [1:0] m_mode();
    if (m_nv[2] && !m_wpq) return 2'd2;
    if (m_nv[1:0] != 0)    return 2'd1;
    return 2'd0;
  endfunction

  task automatic chk(string tag, int act, int exp);
    vectors++;
    if (act != exp) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    #(CLK_T/4);
    if (cmp_on) begin
      chk("R1 status word (model)", status_byte, {m_nv[2], 3'b000, m_nv[1:0], m_wel, m_pend});
      chk("R11 result pulses (model)", {write_ok, write_rej, wrsr_ok, wrsr_rej},
          {m_wok, m_wrej, m_sok, m_srej});
      chk("R12 protection mode (model)", prot_mode, m_mode());
    end
  end

  // stimulus helpers: set at a falling edge, check/clear a quarter period after the capture edge
  task automatic do_write(int pg, bit exp_ok, string tag);
    @(negedge clk); write_page = 9'(pg); write_stb = 1;
    @(posedge clk); #(CLK_T/4); write_stb = 0;
    chk(tag, {write_ok, write_rej}, exp_ok ? 2'b10 : 2'b01);
  endtask

  task automatic do_wrsr(logic [7:0] d, bit exp_ok, string tag);
    @(negedge clk); wrsr_data = d; wrsr_stb = 1;
    @(posedge clk); #(CLK_T/4); wrsr_stb = 0;
    chk(tag, {wrsr_ok, wrsr_rej}, exp_ok ? 2'b10 : 2'b01);
  endtask

  task automatic do_wren();
    @(negedge clk); wren_stb = 1; @(negedge clk); wren_stb = 0;
  endtask

  task automatic do_wrdi();
    @(negedge clk); wrdi_stb = 1; @(negedge clk); wrdi_stb = 0;
  endtask

  task automatic run_cycle(int n);
    @(negedge clk); cycle_busy = 1;
    repeat (n) @(negedge clk);
    cycle_busy = 0;
    repeat (2) @(negedge clk);
  endtask

  task automatic set_pin(logic v);
    @(negedge clk); wp_n = v; repeat (2) @(negedge clk);
  endtask

  initial begin
    #(CLK_T * 200000);
    miscompares++;
    $display("FAIL watchdog expired");
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0; factory_init = 0;
    @(negedge clk);
    chk("R8 reset status", status_byte, 8'h00);
    chk("R12 reset mode", prot_mode, 0);

    do_write(0, 0, "R4 write without WEL");
    chk("R9 no WIP after reject", status_byte, 8'h00);

    do_wren();
    chk("R3 WEL set", status_byte, 8'h02);
    do_write(0, 1, "R4 write accepted");
    chk("R11 WIP with accept", status_byte, 8'h03);
    do_write(1, 0, "R10 write while busy");
    chk("R9 WEL kept on busy reject", status_byte[1], 1);
    run_cycle(4);
    chk("R3 WEL cleared by completion", status_byte, 8'h00);

    do_wren();
    do_wrsr(8'h7F, 1, "R6 status write open");
    chk("R7 old bits until done", status_byte, 8'h03);
    run_cycle(3);
    chk("R7 only three bits changed", status_byte, 8'h0C);
    chk("R12 software mode", prot_mode, 1);

    do_wren();
    do_write(0, 0, "R2 zone 11 page 0");
    chk("R9 WEL kept", status_byte, 8'h0E);
    do_wrsr(8'h04, 1, "R6 zone to 01");
    run_cycle(2);
    chk("R1 zone 01 layout", status_byte, 8'h04);

    do_wren();
    do_write(9'h180, 0, "R2 zone 01 page 180h");
    do_write(9'h17F, 1, "R2 zone 01 page 17Fh");
    run_cycle(2);

    do_wren();
    do_wrsr(8'h08, 1, "R6 zone to 10");
    run_cycle(2);
    do_wren();
    do_write(9'h100, 0, "R2 zone 10 page 100h");
    do_write(9'h0FF, 1, "R2 zone 10 page 0FFh");
    run_cycle(2);

    set_pin(0);
    chk("R12 pin low, lock 0", prot_mode, 1);
    do_wren();
    do_wrsr(8'h88, 1, "R6 lock 0 pin low allowed");
    run_cycle(2);
    chk("R5 lock after pin", status_byte, 8'h88);
    chk("R5 hardware mode", prot_mode, 2);
    do_wren();
    do_wrsr(8'h00, 0, "R5 status write locked");
    chk("R9 WEL kept in lock", status_byte, 8'h8A);
    set_pin(1);
    chk("R5 pin high leaves lock", prot_mode, 1);
    do_wrsr(8'h00, 1, "R6 pin high allowed");
    run_cycle(2);
    chk("R7 cleared", status_byte, 8'h00);
    chk("R12 open mode", prot_mode, 0);

    do_wren();
    do_wrdi();
    chk("R3 WEL cleared by disable", status_byte, 8'h00);

    do_wren();
    do_wrsr(8'h84, 1, "R6 lock while pin high");
    run_cycle(2);
    set_pin(0);
    chk("R5 pin after lock", prot_mode, 2);
    do_wren();
    @(negedge clk); rst = 1; repeat (2) @(negedge clk); rst = 0;
    @(negedge clk);
    chk("R8 reset keeps nv bits", status_byte, 8'h84);
    @(negedge clk); factory_init = 1; @(negedge clk); factory_init = 0;
    chk("R8 factory default", status_byte, 8'h00);

    repeat (3) @(negedge clk);
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule